// File: doc/BRIEF.md
# Packed Rounding Average Unit

This block takes two 256-bit vectors of unsigned packed integers and returns, element by element, their average rounded upward on a tie: each element becomes (a + b + 1) >> 1. The element width is chosen on every operation, either 8 bits (32 elements across the full vector) or 16 bits (16 elements). The sum is formed one bit wider than the element, so the rounding carry is never lost at the top of the range.

Three placement modes decide what lands in the upper 128 bits and which vector is the first operand. Full-width mode averages all 256 bits. Half-width zeroing mode averages the low 128 bits and clears the upper half. In-place mode uses the previous destination contents as the first operand, averages the low 128 bits against the second source, and passes the old destination's upper half through unchanged. The result is registered with a one-cycle latency and an accompanying valid flag.

Top module: `pkavg_unit`

## Requirements
- R1: With `size_i`=0 (byte elements), every output byte k equals (a_k + b_k + 1) >> 1, with both bytes unsigned and the sum taken as 9 bits.
- R2: With `size_i`=1 (word elements), every output 16-bit element equals (a + b + 1) >> 1 over a 17-bit sum, so the carry out of the low byte feeds the high byte of the same element.
- R3: No carry is lost at the range top: 0xFF and 0xFF average to 0xFF in byte mode, 0xFFFF and 0xFFFF to 0xFFFF in word mode, and 0 with 1 rounds up to 1.
- R4: With `mode_i` equal to 2 or 3 (full width), all 256 result bits are averages of `src1_i` and `src2_i`.
- R5: With `mode_i`=1 (half-width zeroing), result bits 127:0 hold the averages of the low halves of `src1_i` and `src2_i`, and bits 255:128 are zero.
- R6: With `mode_i`=0 (in place), result bits 127:0 are averages of `dst_old_i` and `src2_i` with `src1_i` having no effect, and bits 255:128 equal `dst_old_i[255:128]`.
- R7: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high, and `result_o` then holds that operation's result.
- R8: In a cycle with `valid_i` low, `result_o` keeps its previous value whatever the data inputs do.
- R9: A synchronous active-low reset clears `valid_o` and `result_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation request for this cycle |
| size_i | input | 1 | Element width: 0 byte, 1 word |
| mode_i | input | 2 | Placement: 0 in place, 1 half-width zeroing, 2 or 3 full width |
| src1_i | input | 256 | First source vector |
| src2_i | input | 256 | Second source vector |
| dst_old_i | input | 256 | Previous destination contents |
| valid_o | output | 1 | Result valid, one cycle after `valid_i` |
| result_o | output | 256 | Registered averaged vector |

## Verification
The assertions assume the data and control inputs are settled at each rising edge and that `size_i` and `mode_i` carry one of their defined codes; since both are fully decoded (code 3 of the mode behaves as full width), any two-state value qualifies. The identical-operand check assumes the averages of equal elements must return the element itself, which holds in both widths. The stimulus drives every input on the falling edge, sweeps all byte values and many word values through each mode and width, and holds `valid_i` low while scrambling the data to confirm the held result.

// File: rtl/pkavg_pkg.sv
package pkavg_pkg;

   typedef enum logic [1:0] {
      UMODE_KEEP     = 2'b00,
      UMODE_ZERO_HI  = 2'b01,
      UMODE_WIDE     = 2'b10,
      UMODE_WIDE_ALT = 2'b11
   } umode_e;

   typedef enum logic {
      ESZ_BYTE = 1'b0,
      ESZ_WORD = 1'b1
   } esize_e;

   function automatic logic mode_is_wide(umode_e m);
      return (m == UMODE_WIDE) || (m == UMODE_WIDE_ALT);
   endfunction

endpackage

// File: rtl/pkavg_slice.sv
// One adder slice: unsigned add of two slices plus a carry in,
// with the carry out kept as the extra top bit.
module pkavg_slice #(
   parameter int SLICE_W = 8
) (
   input  logic [SLICE_W-1:0] a_i,
   input  logic [SLICE_W-1:0] b_i,
   input  logic               cin_i,
   output logic [SLICE_W:0]   sum_o
);

   generate
      if (SLICE_W < 2) begin : g_bad_w
         $error("pkavg_slice: SLICE_W must be at least 2");
      end
   endgenerate

   always_comb begin
      sum_o = {1'b0, a_i} + {1'b0, b_i} + {{SLICE_W{1'b0}}, cin_i};
   end

endmodule

// File: rtl/pkavg_core.sv
// Segmented rounding averager. Slices are paired into words; in word
// mode the low slice's carry feeds the high slice, in byte mode every
// slice takes the rounding one as its carry in.
module pkavg_core #(
   parameter int DATA_W  = 256,
   parameter int SLICE_W = 8
) (
   input  logic              word_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] avg_o
);

   localparam int NSLICE = DATA_W / SLICE_W;

   generate
      if ((DATA_W % (2 * SLICE_W)) != 0) begin : g_bad_div
         $error("pkavg_core: DATA_W must be a multiple of two slices");
      end
   endgenerate

   logic [SLICE_W:0] sum_w [NSLICE];

   generate
      for (genvar i = 0; i < NSLICE; i++) begin : g_slice
         logic cin_w;
         logic msb_w;

         if ((i % 2) == 1) begin : g_hi
            assign cin_w = word_i ? sum_w[i-1][SLICE_W] : 1'b1;
            assign msb_w = sum_w[i][SLICE_W];
         end else begin : g_lo
            assign cin_w = 1'b1;
            assign msb_w = word_i ? sum_w[i+1][0] : sum_w[i][SLICE_W];
         end

         pkavg_slice #(.SLICE_W(SLICE_W)) u_slice (
            .a_i   (a_i[i*SLICE_W +: SLICE_W]),
            .b_i   (b_i[i*SLICE_W +: SLICE_W]),
            .cin_i (cin_w),
            .sum_o (sum_w[i])
         );

         assign avg_o[i*SLICE_W +: SLICE_W] = {msb_w, sum_w[i][SLICE_W-1:1]};

         // R1: in byte mode a rounded average lies between its operands
         always_comb begin
            if (!word_i) begin
               assert_byte_between_R1: assert (
                  (avg_o[i*SLICE_W +: SLICE_W] >= ((a_i[i*SLICE_W +: SLICE_W] < b_i[i*SLICE_W +: SLICE_W]) ?
                        a_i[i*SLICE_W +: SLICE_W] : b_i[i*SLICE_W +: SLICE_W])) &&
                  (avg_o[i*SLICE_W +: SLICE_W] <= ((a_i[i*SLICE_W +: SLICE_W] < b_i[i*SLICE_W +: SLICE_W]) ?
                        b_i[i*SLICE_W +: SLICE_W] : a_i[i*SLICE_W +: SLICE_W])));
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pkavg_opsel.sv
// First-operand selection: in-place mode averages against the old
// destination, every other mode uses the first source.
module pkavg_opsel #(
   parameter int DATA_W = 256
) (
   input  pkavg_pkg::umode_e mode_i,
   input  logic [DATA_W-1:0] src1_i,
   input  logic [DATA_W-1:0] dst_old_i,
   output logic [DATA_W-1:0] op_a_o
);

   import pkavg_pkg::*;

   always_comb begin
      if (mode_i == UMODE_KEEP) op_a_o = dst_old_i;
      else                      op_a_o = src1_i;
   end

endmodule

// File: rtl/pkavg_merge.sv
// Upper-half placement: computed, cleared, or taken from the old destination.
module pkavg_merge #(
   parameter int DATA_W = 256
) (
   input  pkavg_pkg::umode_e mode_i,
   input  logic [DATA_W-1:0] avg_i,
   input  logic [DATA_W-1:0] dst_old_i,
   output logic [DATA_W-1:0] res_o
);

   import pkavg_pkg::*;

   localparam int LANE_W = DATA_W / 2;

   generate
      if ((DATA_W % 2) != 0) begin : g_bad_half
         $error("pkavg_merge: DATA_W must be even");
      end
   endgenerate

   always_comb begin
      res_o[LANE_W-1:0] = avg_i[LANE_W-1:0];
      unique case (mode_i)
         UMODE_KEEP:    res_o[DATA_W-1:LANE_W] = dst_old_i[DATA_W-1:LANE_W];
         UMODE_ZERO_HI: res_o[DATA_W-1:LANE_W] = '0;
         default:       res_o[DATA_W-1:LANE_W] = avg_i[DATA_W-1:LANE_W];
      endcase
   end

endmodule

// File: rtl/pkavg_unit.sv
module pkavg_unit #(
   parameter int DATA_W  = 256,
   parameter int SLICE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic              size_i,
   input  logic [1:0]        mode_i,
   input  logic [DATA_W-1:0] src1_i,
   input  logic [DATA_W-1:0] src2_i,
   input  logic [DATA_W-1:0] dst_old_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] result_o
);

   import pkavg_pkg::*;

   localparam int LANE_W = DATA_W / 2;

   generate
      if (LANE_W < 2 * SLICE_W) begin : g_bad_lane
         $error("pkavg_unit: each half must hold at least one word element");
      end
   endgenerate

   umode_e            mode_w;
   esize_e            size_w;
   logic [DATA_W-1:0] op_a_w;
   logic [DATA_W-1:0] avg_w;
   logic [DATA_W-1:0] res_w;

   assign mode_w = umode_e'(mode_i);
   assign size_w = esize_e'(size_i);

   pkavg_opsel #(.DATA_W(DATA_W)) u_opsel (
      .mode_i    (mode_w),
      .src1_i    (src1_i),
      .dst_old_i (dst_old_i),
      .op_a_o    (op_a_w)
   );

   pkavg_core #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_core (
      .word_i (size_w == ESZ_WORD),
      .a_i    (op_a_w),
      .b_i    (src2_i),
      .avg_o  (avg_w)
   );

   pkavg_merge #(.DATA_W(DATA_W)) u_merge (
      .mode_i    (mode_w),
      .avg_i     (avg_w),
      .dst_old_i (dst_old_i),
      .res_o     (res_w)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_o  <= 1'b0;
         result_o <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) result_o <= res_w;
      end
   end

   assert_valid_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);

   assert_valid_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);

   assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(result_o));

   assert_zero_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i == 2'b01) |=> (result_o[DATA_W-1:LANE_W] == '0));

   assert_keep_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i == 2'b00) |=>
         (result_o[DATA_W-1:LANE_W] == $past(dst_old_i[DATA_W-1:LANE_W])));

   assert_same_ops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i[1] && src1_i == src2_i) |=> (result_o == $past(src1_i)));

endmodule

// File: tb/sim_pkavg_unit.sv
module sim_pkavg_unit;

   localparam int CLK_PERIOD = 10;
   localparam int W = 256;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         vin = 1'b0;
   logic         size = 1'b0;
   logic [1:0]   mode = 2'b10;
   logic [W-1:0] s1 = '0;
   logic [W-1:0] s2 = '0;
   logic [W-1:0] old = '0;
   logic         vout;
   logic [W-1:0] res;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pkavg_unit u0 (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .valid_i   (vin),
      .size_i    (size),
      .mode_i    (mode),
      .src1_i    (s1),
      .src2_i    (s2),
      .dst_old_i (old),
      .valid_o   (vout),
      .result_o  (res)
   );

   function automatic logic [W-1:0] model(logic [W-1:0] a1, logic [W-1:0] a2,
                                          logic [W-1:0] od, logic wd, logic [1:0] md);
      logic [W-1:0] r;
      logic [W-1:0] a;
      int n;
      a = (md == 2'b00) ? od : a1;
      n = (md[1]) ? W : W/2;
      r = (md == 2'b00) ? {od[W-1:W/2], {(W/2){1'b0}}} : '0;
      if (wd) begin
         for (int e = 0; e < n/16; e++) begin
            int unsigned t;
            t = a[e*16 +: 16] + a2[e*16 +: 16] + 1;
            r[e*16 +: 16] = 16'(t >> 1);
         end
      end else begin
         for (int e = 0; e < n/8; e++) begin
            int unsigned t;
            t = a[e*8 +: 8] + a2[e*8 +: 8] + 1;
            r[e*8 +: 8] = 8'(t >> 1);
         end
      end
      return r;
   endfunction

   task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic check1(string tag, logic got, logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%b exp=%b", tag, got, exp);
      end
   endtask

   // drive on the falling edge, result registered on the next rising edge,
   // sampled on the following falling edge
   task automatic run_op(string tag, logic [W-1:0] a1, logic [W-1:0] a2,
                         logic [W-1:0] od, logic wd, logic [1:0] md);
      s1 = a1; s2 = a2; old = od; size = wd; mode = md; vin = 1'b1;
      @(negedge clk);
      vin = 1'b0;
      check1({tag, " valid R7"}, vout, 1'b1);
      check(tag, res, model(a1, a2, od, wd, md));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] x, y, z, held;
      repeat (3) @(negedge clk);
      // R9: reset state
      check1("R9 reset valid", vout, 1'b0);
      check("R9 reset data", res, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check1("R7 idle valid", vout, 1'b0);

      // R1: byte sweep over every byte value, full width
      for (int v = 0; v < 256; v++) begin
         for (int k = 0; k < 32; k++) begin
            x[k*8 +: 8] = 8'(v + 37*k);
            y[k*8 +: 8] = 8'(v*3 + 101*k + k*k);
         end
         run_op("R1 byte sweep", x, y, '0, 1'b0, 2'b10);
      end

      // R2: word sweep with carries across the byte boundary
      for (int v = 0; v < 256; v++) begin
         for (int k = 0; k < 16; k++) begin
            x[k*16 +: 16] = 16'(v*257 + 4099*k);
            y[k*16 +: 16] = 16'(v*131 + 65000 - 977*k);
         end
         run_op("R2 word sweep", x, y, '0, 1'b1, 2'b11);
      end

      // R3: range-top and rounding corners
      run_op("R3 byte ff+ff", {W{1'b1}}, {W{1'b1}}, '0, 1'b0, 2'b10);
      run_op("R3 word ffff+ffff", {W{1'b1}}, {W{1'b1}}, '0, 1'b1, 2'b10);
      for (int k = 0; k < 32; k++) y[k*8 +: 8] = 8'h01;
      run_op("R3 byte 0+1", '0, y, '0, 1'b0, 2'b10);
      for (int k = 0; k < 16; k++) y[k*16 +: 16] = 16'h0001;
      run_op("R3 word 0+1", '0, y, '0, 1'b1, 2'b10);
      for (int k = 0; k < 16; k++) begin
         x[k*16 +: 16] = 16'h00ff; y[k*16 +: 16] = 16'h0001;
      end
      run_op("R3 word inner carry", x, y, '0, 1'b1, 2'b10);
      run_op("R3 byte no cross carry", x, y, '0, 1'b0, 2'b10);

      // R4 R5 R6: every mode at both widths
      for (int v = 0; v < 128; v++) begin
         for (int k = 0; k < 32; k++) begin
            x[k*8 +: 8] = 8'(v*5 + 19*k);
            y[k*8 +: 8] = 8'(200 - v + 53*k);
            z[k*8 +: 8] = 8'(v*11 + 7*k + 3);
         end
         run_op("R4 R5 R6 mode sweep", x, y, z, v[0], 2'(v >> 1));
      end
      // R6: first source has no effect in place
      run_op("R6 src1 ignored A", '0, y, z, 1'b0, 2'b00);
      run_op("R6 src1 ignored B", {W{1'b1}}, y, z, 1'b0, 2'b00);
      run_op("R5 zero hi", {W{1'b1}}, {W{1'b1}}, {W{1'b1}}, 1'b1, 2'b01);

      // R8: hold with valid low while inputs change
      held = res;
      s1 = ~s1; s2 = 256'h1234; old = ~old; mode = 2'b10; vin = 1'b0;
      @(negedge clk);
      check("R8 hold", res, held);
      check1("R7 valid low", vout, 1'b0);
      @(negedge clk);
      check("R8 hold 2", res, held);

      // R9: reset clears after activity
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 reset after use", res, '0);
      check1("R9 valid after reset", vout, 1'b0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule